// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations so that a memory pipeline can turn a 32-bit virtual address into a 30-bit physical address in one cycle. Pages are 4 KB. The low 12 address bits are the page offset and pass through unchanged. The upper 20 bits form the virtual page number. This number is compared against all eight entries at once. A matching valid entry supplies an 18-bit physical page number.

If no entry matches, the block raises a walk request carrying the virtual page number. It then waits for an external page-table walker to return the physical page number. It installs that mapping and completes the stalled lookup. Each entry holds a use bit, which serves as approximate least-recently-used information for choosing a victim. Each entry also holds a modified bit, which a store sets. A single-cycle flush input invalidates every entry.

The controller has two states. In `ST_IDLE` it accepts lookups. In `ST_WALK` it waits for a refill. The transition LOOKUP_HIT keeps `ST_IDLE`. The transition LOOKUP_MISS goes from `ST_IDLE` to `ST_WALK`. The transition REFILL goes from `ST_WALK` back to `ST_IDLE`.

Top module: `xlat_tlb`

## Requirements
- R1: The physical address reported is {physical page number, va[11:0]}: bits 11..0 equal the virtual address bits 11..0, and bits 29..12 hold the entry's 18-bit page number.
- R2: A request accepted while `lk_ready` is high and `flush` is low, whose va[31:12] equals the page number of a valid entry, gives `lk_done`=1 and `lk_hit`=1 for exactly the next cycle, with the translated address on `lk_pa`.
- R3: An accepted request that matches no valid entry gives `lk_miss`=1 for one cycle and no `lk_done`. From the next cycle, `walk_req` stays high and `walk_vpn` holds va[31:12] unchanged until a refill arrives.
- R4: While `walk_req` is high, `fill_valid` completes the stalled lookup one cycle later: `lk_done`=1, `lk_hit`=0, `lk_pa`={fill_ppn, original offset}. The installed mapping makes later lookups of that page hit.
- R5: A hit with `lk_store`=1 sets the entry's modified bit. A hit with `lk_store`=0 leaves it unchanged. A refill sets it to the stalled request's `lk_store`. `lk_dirty`, valid with `lk_done`, reports the entry's modified bit after the access.
- R6: A hit sets the entry's use bit, and a newly installed entry starts with its use bit set.
- R7: A refill goes into the lowest-numbered invalid entry when one exists.
- R8: With all entries valid and at least one use bit clear, a refill replaces the lowest-numbered entry whose use bit is clear. Other use bits are left as they are.
- R9: With all entries valid and all use bits set, a refill first clears every use bit and then replaces entry 0.
- R10: `flush` clears every valid bit at the next edge. A request presented in the same cycle as `flush` is ignored and produces neither `lk_done` nor `lk_miss`.
- R11: `lk_ready` is high only in `ST_IDLE`. A request while `lk_ready` is low is ignored and does not disturb the pending walk.
- R12: After reset every entry is invalid, `lk_ready` is 1, and `lk_done`, `lk_miss` and `walk_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_store | input | 1 | 1 = store access, 0 = load |
| lk_ready | output | 1 | Controller can accept a lookup |
| lk_done | output | 1 | Lookup complete, `lk_pa` valid |
| lk_hit | output | 1 | Completed lookup hit the buffer |
| lk_miss | output | 1 | Accepted lookup missed; walk started |
| lk_pa | output | 30 | Translated physical address |
| lk_dirty | output | 1 | Modified bit of the entry used |
| walk_req | output | 1 | Waiting for a page-table refill |
| walk_vpn | output | 20 | Virtual page number to walk |
| fill_valid | input | 1 | Refill data valid |
| fill_ppn | input | 18 | Physical page number from walker |

## Verification
The one-match check in the compare stage assumes that the same page number never sits in two valid entries. That holds because a page is only installed after it has missed. The stimulus keeps this true because it never issues a refill without a preceding miss. The flush check assumes that `flush` and a refill do not land in the same cycle, and the random stimulus only flushes from the idle state. A constrained mix of twelve recurring pages with random stores, refill delays, intrusions while busy, and occasional flushes drives the buffer through wraparound and repeated victim selection. Directed sequences pin down each victim rule.

// File: rtl/xl_pkg.sv
package xl_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } tlb_state_e;

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
    parameter int N     = 8,
    parameter int KEY_W = 20,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N-1:0]                ent_valid,
    input  logic [N-1:0][KEY_W-1:0]     ent_key,
    input  logic [KEY_W-1:0]            key,
    output logic                        match_any,
    output logic [IDX_W-1:0]            match_idx
);

    logic [N-1:0] match_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_vec[g] = ent_valid[g] && (ent_key[g] == key);
    end

    always_comb begin
        match_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match_vec[i]) match_idx = match_idx | IDX_W'(i);
        end
    end

    assign match_any = |match_vec;

    // R2
    one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     ent_valid,
    input  logic [N-1:0]     ent_use,
    output logic [IDX_W-1:0] pick_idx,
    output logic             wrap
);

    logic found;

    always_comb begin
        pick_idx = '0;
        found    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && !ent_valid[i]) begin
                pick_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (!found && !ent_use[i]) begin
                pick_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
        wrap = !found;
    end

    // R7
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~&ent_valid) |-> !ent_valid[pick_idx]);

    // R9
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (pick_idx == '0) && (&ent_use) && (&ent_valid));

    // R8
    clear_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&ent_valid && !wrap) |-> !ent_use[pick_idx]);

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 32,
    parameter int PA_W    = 30,
    parameter int OFF_W   = 12,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PPN_W  = PA_W - OFF_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             lk_store,
    output logic             lk_ready,
    output logic             lk_done,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PA_W-1:0]  lk_pa,
    output logic             lk_dirty,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic [PPN_W-1:0] fill_ppn
);
    import xl_pkg::*;

    tlb_state_e state_q, state_d;

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0]             use_q;
    logic [ENTRIES-1:0]             dirty_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;

    logic [VA_W-1:0] pend_va_q;
    logic            pend_st_q;

    logic             accept;
    logic             refill;
    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] vic_idx;
    logic             vic_wrap;

    xlat_cam #(.N(ENTRIES), .KEY_W(VPN_W)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_valid (valid_q),
        .ent_key   (vpn_q),
        .key       (lk_va[VA_W-1:OFF_W]),
        .match_any (hit_any),
        .match_idx (hit_idx)
    );

    xlat_victim #(.N(ENTRIES)) u_vic (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_valid (valid_q),
        .ent_use   (use_q),
        .pick_idx  (vic_idx),
        .wrap      (vic_wrap)
    );

    assign accept   = (state_q == ST_IDLE) && lk_req && !flush;
    assign refill   = (state_q == ST_WALK) && fill_valid;
    assign lk_ready = (state_q == ST_IDLE);
    assign walk_req = (state_q == ST_WALK);
    assign walk_vpn = pend_va_q[VA_W-1:OFF_W];

    // next state: LOOKUP_HIT, LOOKUP_MISS, REFILL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !hit_any) state_d = ST_WALK;
            ST_WALK: if (fill_valid)         state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pending request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_va_q <= '0;
            pend_st_q <= 1'b0;
        end else if (accept && !hit_any) begin
            pend_va_q <= lk_va;
            pend_st_q <= lk_store;
        end
    end

    // entry table
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            use_q   <= '0;
            dirty_q <= '0;
            vpn_q   <= '0;
            ppn_q   <= '0;
        end else begin
            if (flush) valid_q <= '0;
            if (accept && hit_any) begin
                use_q[hit_idx] <= 1'b1;
                if (lk_store) dirty_q[hit_idx] <= 1'b1;
            end
            if (refill) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (vic_wrap) use_q[i] <= 1'b0;
                end
                valid_q[vic_idx] <= 1'b1;
                use_q[vic_idx]   <= 1'b1;
                dirty_q[vic_idx] <= pend_st_q;
                vpn_q[vic_idx]   <= pend_va_q[VA_W-1:OFF_W];
                ppn_q[vic_idx]   <= fill_ppn;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_done  <= 1'b0;
            lk_hit   <= 1'b0;
            lk_miss  <= 1'b0;
            lk_pa    <= '0;
            lk_dirty <= 1'b0;
        end else begin
            lk_done <= 1'b0;
            lk_hit  <= 1'b0;
            lk_miss <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && hit_any) begin
                        lk_done  <= 1'b1;
                        lk_hit   <= 1'b1;
                        lk_pa    <= {ppn_q[hit_idx], lk_va[OFF_W-1:0]};
                        lk_dirty <= dirty_q[hit_idx] | lk_store;
                    end else if (accept) begin
                        lk_miss  <= 1'b1;
                    end
                end
                ST_WALK: begin
                    if (fill_valid) begin
                        lk_done  <= 1'b1;
                        lk_pa    <= {fill_ppn, pend_va_q[OFF_W-1:0]};
                        lk_dirty <= pend_st_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    hit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_done && !lk_miss);

    // R3
    miss_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> walk_req && !lk_done);

    // R3
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !fill_valid |=> walk_req && $stable(walk_vpn));

    // R4
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && fill_valid |=> lk_done && !lk_hit && lk_ready);

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !(walk_req && fill_valid) |=> (valid_q == '0));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_ready |=> !lk_miss && !lk_hit);

endmodule

// File: tb/xlat_tlb_tb.sv
module xlat_tlb_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_store = 1'b0;
    logic        lk_ready, lk_done, lk_hit, lk_miss, lk_dirty, walk_req;
    logic [29:0] lk_pa;
    logic [19:0] walk_vpn;
    logic        fill_valid = 1'b0;
    logic [17:0] fill_ppn = '0;

    int vectors = 0;
    int fails   = 0;

    bit          mv [8];
    logic [19:0] mvpn [8];
    logic [17:0] mppn [8];
    bit          md [8];
    bit          mr [8];

    always #2.5 clk = ~clk;

    xlat_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_req(lk_req),
        .lk_va(lk_va), .lk_store(lk_store), .lk_ready(lk_ready),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_pa(lk_pa), .lk_dirty(lk_dirty), .walk_req(walk_req),
        .walk_vpn(walk_vpn), .fill_valid(fill_valid), .fill_ppn(fill_ppn)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [17:0] fmap(input logic [19:0] vpn);
        return vpn[17:0] ^ 18'h15A3C;
    endfunction

    function automatic int model_find(input logic [19:0] vpn);
        for (int i = 0; i < 8; i++) if (mv[i] && mvpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic int model_victim();
        for (int i = 0; i < 8; i++) if (!mv[i]) return i;
        for (int i = 0; i < 8; i++) if (!mr[i]) return i;
        for (int i = 0; i < 8; i++) mr[i] = 1'b0;
        return 0;
    endfunction

    task automatic lookup(input logic [31:0] va, input bit st, input string tag,
                          input bit intrude);
        int hi;
        int v;
        hi = model_find(va[31:12]);
        lk_req = 1'b1; lk_va = va; lk_store = st;
        @(posedge clk); @(negedge clk);
        lk_req = 1'b0;
        if (hi >= 0) begin
            chk(lk_done && lk_hit && !lk_miss, tag, "hit expected", {29'b0, lk_done, lk_hit, lk_miss}, 32'h6);
            chk(lk_pa == {mppn[hi], va[11:0]}, "R1", "hit pa", {2'b0, lk_pa}, {2'b0, mppn[hi], va[11:0]});
            chk(lk_dirty == (md[hi] | st), "R5", "hit dirty", {31'b0, lk_dirty}, {31'b0, md[hi] | st});
            mr[hi] = 1'b1;
            if (st) md[hi] = 1'b1;
        end else begin
            chk(lk_miss && !lk_done, tag, "miss expected", {30'b0, lk_miss, lk_done}, 32'h2);
            chk(walk_req && walk_vpn == va[31:12], "R3", "walk vpn", {12'b0, walk_vpn}, {12'b0, va[31:12]});
            repeat ($urandom % 4) begin
                if (intrude) begin
                    lk_req = 1'b1; lk_va = va ^ 32'h5555_5000; lk_store = 1'b1;
                end
                @(posedge clk); @(negedge clk);
                lk_req = 1'b0;
                chk(!lk_done && !lk_miss && !lk_ready, "R11", "busy ignore", {29'b0, lk_done, lk_miss, lk_ready}, 32'h0);
                chk(walk_req && walk_vpn == va[31:12], "R3", "walk hold", {12'b0, walk_vpn}, {12'b0, va[31:12]});
            end
            fill_valid = 1'b1; fill_ppn = fmap(va[31:12]);
            @(posedge clk); @(negedge clk);
            fill_valid = 1'b0;
            chk(lk_done && !lk_hit && lk_ready, "R4", "refill done", {29'b0, lk_done, lk_hit, lk_ready}, 32'h5);
            chk(lk_pa == {fmap(va[31:12]), va[11:0]}, "R1", "refill pa", {2'b0, lk_pa}, {2'b0, fmap(va[31:12]), va[11:0]});
            chk(lk_dirty == st, "R5", "refill dirty", {31'b0, lk_dirty}, {31'b0, st});
            v = model_victim();
            mv[v] = 1'b1; mvpn[v] = va[31:12]; mppn[v] = fmap(va[31:12]);
            md[v] = st; mr[v] = 1'b1;
        end
    endtask

    task automatic do_flush(input bit with_req);
        flush = 1'b1;
        lk_req = with_req; lk_va = {20'h00100, 12'h0}; lk_store = 1'b0;
        @(posedge clk); @(negedge clk);
        flush = 1'b0; lk_req = 1'b0;
        chk(!lk_done && !lk_miss && lk_ready, "R10", "flush ignores request", {29'b0, lk_done, lk_miss, lk_ready}, 32'h1);
        for (int i = 0; i < 8; i++) mv[i] = 1'b0;
    endtask

    function automatic logic [31:0] page(input int k);
        return {20'h00100 + 20'(k * 7), 12'($urandom)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog actual=hang expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin
            mv[i] = 0; md[i] = 0; mr[i] = 0; mvpn[i] = '0; mppn[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lk_ready && !lk_done && !lk_miss && !walk_req, "R12", "reset state",
            {28'b0, lk_ready, lk_done, lk_miss, walk_req}, 32'h8);

        // first fill goes to entry 0, then hits
        lookup(page(0), 1'b0, "R12", 1'b0);
        lookup(page(0), 1'b0, "R4", 1'b0);
        // flush with a concurrent request, then the page misses again
        do_flush(1'b1);
        lookup(page(0), 1'b0, "R10", 1'b0);
        do_flush(1'b0);
        // fill all eight entries through invalid slots
        for (int k = 0; k < 8; k++) lookup(page(k), 1'b0, "R7", 1'b1);
        lookup(page(1), 1'b1, "R6", 1'b0);   // R5 store hit sets modified bit
        lookup(page(1), 1'b0, "R5", 1'b0);   // load keeps it
        // all use bits set: wrap, entry 0 replaced
        lookup(page(8), 1'b0, "R9", 1'b0);
        lookup(page(0), 1'b0, "R9", 1'b0);   // evicted page misses, replaces entry 1
        lookup(page(1), 1'b0, "R8", 1'b0);   // so page 1 now misses
        lookup(page(8), 1'b1, "R6", 1'b0);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 40 == 0) do_flush($urandom % 2 == 1);
            else lookup(page($urandom % 12), $urandom % 3 == 0, "R2", $urandom % 2 == 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule